// File: doc/BRIEF.md
# APB Protection-Aware Access Filter

This block sits on an APB link between a requester and a memory-mapped completer that keeps both program code and data. At the setup phase of every transfer it compares the address with a small set of configured windows and weighs the 3-bit protection attribute against the policy of the window that matches. Windows can be declared fetch-only code, can demand privileged mode, and can demand the secure state. Each of these checks is made separately.

A transfer that passes is forwarded unchanged. The completer's wait states and error flag come back to the requester as they are. A refused transfer never selects the completer. The filter answers it itself in the first access-phase cycle with an error. The windows come either from configuration ports or from static parameters, and a parameter picks which.

Top module: `apb_prot_filter`

## Requirements
- R1: While reset is held and straight after it, the downstream select is low and the upstream error flag is low.
- R2: An address that matches no enabled window passes through. The downstream select, ready, read data and error follow the completer, and the write data and protection reach it unchanged.
- R3: A window's policy nibble is: bit 0 enable, bit 1 code-only, bit 2 privilege required, bit 3 secure required. A read into a code-only window with protection bit 2 high (instruction fetch) is permitted.
- R4: In a code-only window, any data-type access (protection bit 2 low) is refused. Any write is also refused, whatever the value of protection bit 2.
- R5: A window that requires privilege refuses transfers with protection bit 0 low (user mode) and permits them when bit 0 is high.
- R6: A window that requires the secure state refuses transfers with protection bit 1 high (non-secure) and permits them when bit 1 is low.
- R7: A refused transfer never asserts the downstream select. It completes in its first access-phase cycle with ready high, error high and read data zero.
- R8: For a permitted transfer, upstream ready tracks downstream ready through every wait state, and a downstream error is forwarded.
- R9: The upstream error flag is high only in a cycle where select, enable and ready are all high.
- R10: The permit/refuse decision is taken at the setup phase and held for the whole access phase. Changing the window configuration during wait states does not alter the outcome of the transfer in progress.
- R11: When several enabled windows match, the lowest-numbered one decides. A window whose enable bit is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | NREG*AW | Window base addresses, window i in bits [i*AW +: AW] |
| cfg_mask | input | NREG*AW | Window compare masks; a 1 bit is compared |
| cfg_policy | input | NREG*4 | Window policy nibbles (enable, code-only, privilege, secure) |
| up_sel | input | 1 | Requester select |
| up_enable | input | 1 | Requester enable (access phase) |
| up_write | input | 1 | Requester write strobe |
| up_addr | input | AW | Requester address |
| up_wdata | input | DW | Requester write data |
| up_prot | input | 3 | Protection: bit0 privileged, bit1 non-secure, bit2 instruction |
| up_rdata | output | DW | Read data back to requester |
| up_ready | output | 1 | Ready back to requester |
| up_err | output | 1 | Error back to requester |
| dn_sel | output | 1 | Completer select |
| dn_enable | output | 1 | Completer enable |
| dn_write | output | 1 | Completer write strobe |
| dn_addr | output | AW | Completer address |
| dn_wdata | output | DW | Completer write data |
| dn_prot | output | 3 | Completer protection |
| dn_rdata | input | DW | Completer read data |
| dn_ready | input | 1 | Completer ready |
| dn_err | input | 1 | Completer error |

## Verification
The decision register loads at the clock edge that ends the setup phase. A refused transfer is therefore answered in the very first access-phase cycle, and a permitted one completes in the access cycle where the completer's ready rises, after as many extra cycles as the completer inserts. The bench changes inputs on the falling edge and reads outputs shortly after it. It counts access-phase cycles until ready and compares that count with the wait states it asked its completer model for. It also checks that the error flag stays low in every cycle before completion. For the configuration-change case, the bench rewrites a window only after the setup edge has passed, so the check reaches the held decision and not the live one.

// File: rtl/apb_prot_filter_pkg.sv
package apb_prot_filter_pkg;
   localparam int PROT_W     = 3;
   localparam int PROT_PRIV  = 0;   // 1 = privileged
   localparam int PROT_NSEC  = 1;   // 1 = non-secure
   localparam int PROT_INSTR = 2;   // 1 = instruction fetch
   localparam int POL_W      = 4;

   typedef struct packed {
      logic need_sec;
      logic need_priv;
      logic code_only;
      logic en;
   } win_policy_t;
endpackage

// File: rtl/apf_window_match.sv
module apf_window_match #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] mask,
   input  logic          en,
   output logic          hit
);
   assign hit = en && ((addr & mask) == (base & mask));
endmodule

// File: rtl/apf_rule_eval.sv
module apf_rule_eval
   import apb_prot_filter_pkg::*;
#(
   parameter int NREG = 4
) (
   input  logic [NREG-1:0]   hit,
   input  logic [NREG-1:0]   code_only,
   input  logic [NREG-1:0]   need_priv,
   input  logic [NREG-1:0]   need_sec,
   input  logic              write,
   input  logic [PROT_W-1:0] prot,
   output logic              deny
);
   logic [NREG-1:0] first_hit;
   logic            w_code, w_priv, w_sec, any_hit;

   // Lowest-numbered hit wins (R11)
   always_comb begin
      first_hit = '0;
      for (int i = NREG-1; i >= 0; i--) begin
         if (hit[i]) first_hit = NREG'(1) << i;
      end
   end

   assign any_hit = |first_hit;
   assign w_code  = |(first_hit & code_only);
   assign w_priv  = |(first_hit & need_priv);
   assign w_sec   = |(first_hit & need_sec);

   assign deny = any_hit && (
                    (w_code && (write || !prot[PROT_INSTR])) ||
                    (w_priv && !prot[PROT_PRIV]) ||
                    (w_sec  &&  prot[PROT_NSEC]));

   // The winner selection must never name two windows (R11)
   always_comb begin
      p_single_winner_r11: assert ($onehot0(first_hit))
         else $error("p_single_winner_r11");
   end

   // Any write landing in a code-only winner is refused (R4)
   always_comb begin
      if (any_hit && w_code && write)
         p_code_write_r4: assert (deny) else $error("p_code_write_r4");
   end
endmodule

// File: rtl/apb_prot_filter.sv
module apb_prot_filter
   import apb_prot_filter_pkg::*;
#(
   parameter int                    NREG           = 4,
   parameter int                    AW             = 32,
   parameter int                    DW             = 32,
   parameter bit                    CFG_FROM_PORTS = 1'b1,
   parameter logic [NREG*AW-1:0]    STATIC_BASE    = '0,
   parameter logic [NREG*AW-1:0]    STATIC_MASK    = '0,
   parameter logic [NREG*POL_W-1:0] STATIC_POLICY  = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NREG*AW-1:0]      cfg_base,
   input  logic [NREG*AW-1:0]      cfg_mask,
   input  logic [NREG*POL_W-1:0]   cfg_policy,
   input  logic                    up_sel,
   input  logic                    up_enable,
   input  logic                    up_write,
   input  logic [AW-1:0]           up_addr,
   input  logic [DW-1:0]           up_wdata,
   input  logic [PROT_W-1:0]       up_prot,
   output logic [DW-1:0]           up_rdata,
   output logic                    up_ready,
   output logic                    up_err,
   output logic                    dn_sel,
   output logic                    dn_enable,
   output logic                    dn_write,
   output logic [AW-1:0]           dn_addr,
   output logic [DW-1:0]           dn_wdata,
   output logic [PROT_W-1:0]       dn_prot,
   input  logic [DW-1:0]           dn_rdata,
   input  logic                    dn_ready,
   input  logic                    dn_err
);
   localparam int CFG_W = NREG * (2*AW + POL_W);

   initial begin
      a_nreg_range: assert (NREG >= 1 && NREG <= 16) else $error("NREG out of range");
      a_aw_range:   assert (AW >= 8 && AW <= 64)     else $error("AW out of range");
      a_dw_range:   assert (DW >= 8 && DW <= 64)     else $error("DW out of range");
      a_cfg_width:  assert (CFG_W > 0)               else $error("empty config");
   end

   logic [NREG*AW-1:0]    base_v, mask_v;
   logic [NREG*POL_W-1:0] pol_v;

   generate
      if (CFG_FROM_PORTS) begin : g_cfg_ports
         assign base_v = cfg_base;
         assign mask_v = cfg_mask;
         assign pol_v  = cfg_policy;
      end else begin : g_cfg_static
         logic cfg_unused;
         assign cfg_unused = ^{cfg_base, cfg_mask, cfg_policy};
         assign base_v = STATIC_BASE;
         assign mask_v = STATIC_MASK;
         assign pol_v  = STATIC_POLICY;
      end
   endgenerate

   logic [NREG-1:0] hit, code_only, need_priv, need_sec;

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_win
         win_policy_t pol;
         assign pol          = win_policy_t'(pol_v[g*POL_W +: POL_W]);
         assign code_only[g] = pol.code_only;
         assign need_priv[g] = pol.need_priv;
         assign need_sec[g]  = pol.need_sec;

         apf_window_match #(.AW(AW)) u_match (
            .addr (up_addr),
            .base (base_v[g*AW +: AW]),
            .mask (mask_v[g*AW +: AW]),
            .en   (pol.en),
            .hit  (hit[g])
         );
      end
   endgenerate

   logic deny_now, deny_q;

   apf_rule_eval #(.NREG(NREG)) u_eval (
      .hit       (hit),
      .code_only (code_only),
      .need_priv (need_priv),
      .need_sec  (need_sec),
      .write     (up_write),
      .prot      (up_prot),
      .deny      (deny_now)
   );

   logic setup_ph, access_ph;
   assign setup_ph  = up_sel && !up_enable;
   assign access_ph = up_sel &&  up_enable;

   // Decision captured at the setup edge, frozen through wait states
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        deny_q <= 1'b0;
      else if (setup_ph) deny_q <= deny_now;
   end

   assign dn_sel    = up_sel && (up_enable ? !deny_q : !deny_now);
   assign dn_enable = up_enable && dn_sel;
   assign dn_write  = up_write;
   assign dn_addr   = up_addr;
   assign dn_wdata  = up_wdata;
   assign dn_prot   = up_prot;

   logic local_done;
   assign local_done = access_ph && deny_q;

   assign up_ready = local_done ? 1'b1 : (dn_enable && dn_ready);
   assign up_err   = local_done ? 1'b1 : (dn_enable && dn_ready && dn_err);
   assign up_rdata = local_done ? '0   : dn_rdata;

   p_local_refusal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (access_ph && $past(setup_ph && deny_now))
         |-> (up_ready && up_err && up_rdata == '0 && !dn_sel));

   p_err_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
      up_err |-> (up_sel && up_enable && up_ready));

   p_held_decision_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (access_ph && $past(access_ph)) |-> $stable(deny_q));

   p_wait_forward_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (access_ph && dn_sel) |-> (up_ready == dn_ready));

   p_idle_no_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !up_sel |-> (!dn_sel && !up_err));
endmodule

// File: tb/apb_prot_filter_bench.sv
module apb_prot_filter_bench;
   localparam int  CLK_PERIOD = 10;
   localparam int  NREG = 4;
   localparam int  AW   = 32;
   localparam int  DW   = 32;
   localparam logic [31:0] RD_KEY = 32'h5A5A_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [NREG*AW-1:0] cfg_base, cfg_mask;
   logic [NREG*4-1:0]  cfg_policy;
   logic up_sel = 0, up_enable = 0, up_write = 0;
   logic [AW-1:0] up_addr = '0;
   logic [DW-1:0] up_wdata = '0;
   logic [2:0]    up_prot = '0;
   logic [DW-1:0] up_rdata;
   logic up_ready, up_err;
   logic dn_sel, dn_enable, dn_write;
   logic [AW-1:0] dn_addr;
   logic [DW-1:0] dn_wdata;
   logic [2:0]    dn_prot;
   logic [DW-1:0] dn_rdata;
   logic dn_ready, dn_err;

   apb_prot_filter #(.NREG(NREG), .AW(AW), .DW(DW)) u_apb_prot_filter (
      .clk, .rst_n, .cfg_base, .cfg_mask, .cfg_policy,
      .up_sel, .up_enable, .up_write, .up_addr, .up_wdata, .up_prot,
      .up_rdata, .up_ready, .up_err,
      .dn_sel, .dn_enable, .dn_write, .dn_addr, .dn_wdata, .dn_prot,
      .dn_rdata, .dn_ready, .dn_err
   );

   // Completer model
   int   cur_waits = 0;
   logic cur_err   = 1'b0;
   int   wcnt;
   logic saw_sel;
   logic [DW-1:0] got_wdata;
   logic [2:0]    got_prot;
   assign dn_ready = dn_sel && dn_enable && (wcnt == cur_waits);
   assign dn_err   = dn_ready && cur_err;
   assign dn_rdata = dn_addr ^ RD_KEY;
   always_ff @(posedge clk) begin
      if (!(dn_sel && dn_enable)) wcnt <= 0;
      else if (!dn_ready)         wcnt <= wcnt + 1;
      if (dn_sel) saw_sel <= 1'b1;
      if (dn_sel && dn_enable && dn_ready && dn_write) begin
         got_wdata <= dn_wdata;
         got_prot  <= dn_prot;
      end
   end

   int n_tests = 0, n_fail = 0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One transfer; result read in the cycle ready is high
   task automatic xfer(input logic [31:0] a, input logic wr, input logic [2:0] pr,
                       input int waits, input logic serr, input logic mutate,
                       input string req,
                       output logic [DW-1:0] rd, output logic er, output int cyc,
                       output logic seen);
      cur_waits = waits;
      cur_err   = serr;
      @(negedge clk);
      saw_sel   = 1'b0;
      up_sel = 1; up_enable = 0; up_write = wr; up_addr = a; up_prot = pr;
      up_wdata = a ^ 32'h0F0F_F0F0;
      @(negedge clk);
      up_enable = 1;
      if (mutate) begin
         cfg_base[1*AW +: AW] = a;   // would now require privilege
      end
      cyc = 0;
      #1;
      while (!up_ready && cyc < 40) begin
         check({req, " err low while waiting (R9)"}, 64'(up_err), 64'd0);
         @(negedge clk);
         #1;
         cyc++;
      end
      rd = up_rdata; er = up_err;
      @(posedge clk);
      #1;
      seen = saw_sel;
      @(negedge clk);
      up_sel = 0; up_enable = 0;
   endtask

   typedef struct packed {
      logic [31:0] addr;
      logic        wr;
      logic [2:0]  prot;
      logic [3:0]  waits;
      logic        deny;
      logic [3:0]  req;
   } vec_t;

   // prot: bit0 privileged, bit1 non-secure, bit2 instruction
   localparam vec_t VECS [12] = '{
      '{32'h0000_4000, 1'b0, 3'b000, 4'd0, 1'b0, 4'd2},  // R2 unmatched read
      '{32'h0000_4004, 1'b1, 3'b000, 4'd2, 1'b0, 4'd2},  // R2 unmatched write, waits
      '{32'h0000_1010, 1'b0, 3'b100, 4'd1, 1'b0, 4'd3},  // R3 fetch from code
      '{32'h0000_1010, 1'b0, 3'b000, 4'd0, 1'b1, 4'd4},  // R4 data read of code
      '{32'h0000_1010, 1'b1, 3'b000, 4'd0, 1'b1, 4'd4},  // R4 data write to code
      '{32'h0000_1010, 1'b1, 3'b100, 4'd0, 1'b1, 4'd4},  // R4 instruction write
      '{32'h0000_2000, 1'b0, 3'b000, 4'd0, 1'b1, 4'd5},  // R5 user refused
      '{32'h0000_2000, 1'b0, 3'b001, 4'd1, 1'b0, 4'd5},  // R5 privileged ok
      '{32'h0000_3000, 1'b0, 3'b010, 4'd0, 1'b1, 4'd6},  // R6 non-secure refused
      '{32'h0000_3000, 1'b1, 3'b000, 4'd3, 1'b0, 4'd6},  // R6 secure ok
      '{32'h0000_1900, 1'b0, 3'b000, 4'd0, 1'b1, 4'd11}, // R11 window 0 wins
      '{32'h0000_1900, 1'b0, 3'b100, 4'd0, 1'b0, 4'd11}  // R11 fetch ok
   };

   initial begin
      #(CLK_PERIOD * 20000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [DW-1:0] rd; logic er; int cyc; logic seen;
      string tag;
      cfg_base = '0; cfg_mask = '0; cfg_policy = '0;
      cfg_base[0*AW +: AW] = 32'h1000; cfg_mask[0*AW +: AW] = 32'hFFFF_F000; cfg_policy[0 +: 4] = 4'b0011;
      cfg_base[1*AW +: AW] = 32'h2000; cfg_mask[1*AW +: AW] = 32'hFFFF_F000; cfg_policy[4 +: 4] = 4'b0101;
      cfg_base[2*AW +: AW] = 32'h3000; cfg_mask[2*AW +: AW] = 32'hFFFF_F000; cfg_policy[8 +: 4] = 4'b1001;
      cfg_base[3*AW +: AW] = 32'h1800; cfg_mask[3*AW +: AW] = 32'hFFFF_F800; cfg_policy[12 +: 4] = 4'b0001;

      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 sel in reset", 64'(dn_sel), 64'd0);
      check("R1 err in reset", 64'(up_err), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 sel after reset", 64'(dn_sel), 64'd0);
      check("R1 err after reset", 64'(up_err), 64'd0);

      foreach (VECS[i]) begin
         vec_t v = VECS[i];
         tag = $sformatf("R%0d vec%0d", v.req, i);
         xfer(v.addr, v.wr, v.prot, int'(v.waits), 1'b0, 1'b0, tag, rd, er, cyc, seen);
         if (v.deny) begin   // R7 local refusal
            check({tag, " R7 err"},   64'(er),   64'd1);
            check({tag, " R7 rdata"}, 64'(rd),   64'd0);
            check({tag, " R7 cycles"},64'(cyc),  64'd0);
            check({tag, " R7 no sel"},64'(seen), 64'd0);
         end else begin      // R8 pass-through with waits
            check({tag, " R8 err"},    64'(er),   64'd0);
            check({tag, " R8 cycles"}, 64'(cyc),  64'(v.waits));
            check({tag, " R2 sel"},    64'(seen), 64'd1);
            if (v.wr) begin
               check({tag, " R2 wdata"}, 64'(got_wdata), 64'(v.addr ^ 32'h0F0F_F0F0));
               check({tag, " R2 prot"},  64'(got_prot),  64'(v.prot));
            end else begin
               check({tag, " R2 rdata"}, 64'(rd), 64'(v.addr ^ RD_KEY));
            end
         end
      end

      // R8 downstream error forwarded after waits
      xfer(32'h0000_4100, 1'b0, 3'b000, 2, 1'b1, 1'b0, "R8", rd, er, cyc, seen);
      check("R8 slave err forwarded", 64'(er), 64'd1);
      check("R8 slave err cycles", 64'(cyc), 64'd2);

      // R10 config rewritten during wait states: outcome unchanged
      xfer(32'h0000_5000, 1'b0, 3'b000, 3, 1'b0, 1'b1, "R10", rd, er, cyc, seen);
      check("R10 held permit err", 64'(er), 64'd0);
      check("R10 held permit cycles", 64'(cyc), 64'd3);
      // now the new window applies at the next setup phase (R5)
      xfer(32'h0000_5000, 1'b0, 3'b000, 0, 1'b0, 1'b0, "R10", rd, er, cyc, seen);
      check("R10 next transfer refused", 64'(er), 64'd1);
      cfg_base[1*AW +: AW] = 32'h2000;

      // R11 disabled window 0 ignored: window 3 (no restriction) decides
      cfg_policy[0 +: 4] = 4'b0010;
      xfer(32'h0000_1900, 1'b0, 3'b000, 1, 1'b0, 1'b0, "R11", rd, er, cyc, seen);
      check("R11 disabled window ignored err", 64'(er), 64'd0);
      check("R11 disabled window rdata", 64'(rd), 64'(32'h1900 ^ RD_KEY));
      xfer(32'h0000_1010, 1'b1, 3'b000, 0, 1'b0, 1'b0, "R11", rd, er, cyc, seen);
      check("R11 disabled code window write passes", 64'(er), 64'd0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule